// File: doc/BRIEF.md
# Write Protection Command Sequencer

This block sits in front of a page write controller and screens every write cycle that reaches it. It looks for two fixed command strings made of address and data pairs. One string switches protection on and, in the same step, opens one load window. The other, six writes long, switches protection off. While protection is on, a write that does not follow an unlock is dropped. After an unlock, the writes of one byte or page load pass through. Protection is back in force once the controller reports that the load's programming has finished. Command writes are never passed on to be stored.

Writes arrive on a valid/ready stream and leave on a second valid/ready stream towards the controller. An input write is taken when `in_valid` and `in_ready` are both high at a clock edge. A forwarded write is taken when `out_valid` and `out_ready` are both high. While protection is off, the first two bytes of a possible command are held back. If the string then breaks, those held bytes are released in their original order, and the input stays stalled while they drain. A write that is dropped or swallowed is taken at once, whatever `out_ready` is. The protection bit stands in for a nonvolatile flag, so only `rst_n` clears it, which returns the block to its factory default.

Top module: `wp_cmd_seq`

## Requirements
- R1: After reset, `prot_on` is 0, `wr_permit` is 1 and `out_valid` is 0.
- R2: With protection off and no command in progress, a write is forwarded with its address and data unchanged.
- R3: The arm string 0xAA@0x1555, 0x55@0x0AAA, 0xA0@0x1555 (data@address, in that order) sets `prot_on` whether or not it was set before, opens a load window, and forwards none of its three writes.
- R4: While the window is open, every write is forwarded. A one-cycle pulse on `load_done` closes the window and leaves `prot_on` at 1.
- R5: With protection on and the window closed, a write outside a command string is accepted and dropped, and `wr_permit` is 0.
- R6: The six-write string 0xAA@0x1555, 0x55@0x0AAA, 0x80@0x1555, 0xAA@0x1555, 0x55@0x0AAA, 0x20@0x1555 clears `prot_on`. None of the six writes is forwarded, and later plain writes are forwarded.
- R7: With protection off, a write that breaks the string after its first or second byte causes the held bytes to be forwarded in arrival order, followed by the breaking write as plain data, even when that write is itself 0xAA@0x1555.
- R8: A write that breaks the six-write string after its third byte drops the command bytes already seen. With protection off, the breaking write is forwarded. With protection on, it is dropped. In both cases matching starts again from the first byte.
- R9: `out_valid`, `out_addr` and `out_data` stay unchanged while `out_ready` is low, and `in_ready` stays low while held bytes drain.
- R10: `wr_permit` is high exactly when protection is off or a load window is open, and nothing is forwarded while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also clears the protection flag |
| in_valid | input | 1 | Input write present |
| in_ready | output | 1 | Input write taken this cycle |
| in_addr | input | 13 | Address of the input write |
| in_data | input | 8 | Data of the input write |
| out_valid | output | 1 | Forwarded write present |
| out_ready | input | 1 | Controller takes the forwarded write |
| out_addr | output | 13 | Address of the forwarded write |
| out_data | output | 8 | Data of the forwarded write |
| load_done | input | 1 | Pulse from the controller when a load has finished programming |
| prot_on | output | 1 | Protection flag |
| wr_permit | output | 1 | Writes may currently be stored |

## Verification
A matcher stuck at the wrong position shows up at the ports on the very next write. Under protection it either lets a data byte through or swallows a write that should have been taken. Without protection it leaves the output stream short by, or padded with, the held bytes. A held-byte buffer that drops or reorders an entry is seen in the forwarded order within three handshakes of the break. A flag or window bit that is off by one state shows on `prot_on` or `wr_permit` in the cycle after the command's last write or the `load_done` pulse. For this reason the bench breaks each string at every position, with every single-bit corruption of the expected byte, in both protection states.

// File: rtl/wpseq_pkg.sv
package wpseq_pkg;
  parameter int AW       = 13;
  parameter int DW       = 8;
  parameter int SEQ_LEN  = 6;
  parameter int HOLD_MAX = 2;
  parameter int STW      = $clog2(SEQ_LEN);
  parameter int HCW      = $clog2(HOLD_MAX + 1);

  parameter logic [AW-1:0] KEY_ADDR_HI = 13'h1555;
  parameter logic [AW-1:0] KEY_ADDR_LO = 13'h0AAA;
  parameter logic [DW-1:0] KEY_D_FIRST = 8'hAA;
  parameter logic [DW-1:0] KEY_D_SECOND = 8'h55;
  parameter logic [DW-1:0] KEY_D_ARM   = 8'hA0;
  parameter logic [DW-1:0] KEY_D_EXT   = 8'h80;
  parameter logic [DW-1:0] KEY_D_OFF   = 8'h20;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } wr_t;
endpackage

// File: rtl/wpseq_match.sv
module wpseq_match
  import wpseq_pkg::*;
(
  input  logic [STW-1:0] step,
  input  wr_t            wr,
  output logic           hit_step,
  output logic           hit_arm,
  output logic           hit_ext
);
  logic [AW-1:0] want_a;
  logic [DW-1:0] want_d;

  // Expected byte for each position of the six-write string;
  // position 2 forks into arm or extend and is handled apart.
  always_comb begin
    want_a = KEY_ADDR_HI;
    want_d = KEY_D_FIRST;
    case (step)
      STW'(1), STW'(4): begin want_a = KEY_ADDR_LO; want_d = KEY_D_SECOND; end
      STW'(5):          begin want_a = KEY_ADDR_HI; want_d = KEY_D_OFF;    end
      default:          begin want_a = KEY_ADDR_HI; want_d = KEY_D_FIRST;  end
    endcase
  end

  assign hit_step = (step != STW'(2)) && (wr.addr == want_a) && (wr.data == want_d);
  assign hit_arm  = (step == STW'(2)) && (wr.addr == KEY_ADDR_HI) && (wr.data == KEY_D_ARM);
  assign hit_ext  = (step == STW'(2)) && (wr.addr == KEY_ADDR_HI) && (wr.data == KEY_D_EXT);
endmodule

// File: rtl/wpseq_hold.sv
module wpseq_hold #(
  parameter int DEPTH = 2,
  parameter int W     = 21,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_d,
  input  logic          pop,
  input  logic          clear,
  output logic [W-1:0]  head,
  output logic [CW-1:0] cnt
);
  logic [DEPTH-1:0][W-1:0] slot;
  logic [CW-1:0]           cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (push)  cnt_q <= cnt_q + CW'(1);
    else if (pop)   cnt_q <= cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push && cnt_q == CW'(i))
          slot[i] <= push_d;
        else if (pop)
          slot[i] <= (i == DEPTH - 1) ? '0 : slot[(i + 1) % DEPTH];
      end
    end
  end

  assign head = slot[0];
  assign cnt  = cnt_q;
endmodule

// File: rtl/wp_cmd_seq.sv
module wp_cmd_seq
  import wpseq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data,
  input  logic          load_done,
  output logic          prot_on,
  output logic          wr_permit
);
  logic           prot_q, prot_n;
  logic           win_q, win_n;
  logic           drain_q, drain_n;
  logic           pass_q, pass_n;
  logic [STW-1:0] step_q, step_n;

  wr_t            wr_in, head, out_w;
  logic           hit_step, hit_arm, hit_ext;
  logic           push, pop, clear;
  logic [HCW-1:0] hcnt;

  assign wr_in = '{addr: in_addr, data: in_data};

  wpseq_match u_match (
    .step     (step_q),
    .wr       (wr_in),
    .hit_step (hit_step),
    .hit_arm  (hit_arm),
    .hit_ext  (hit_ext)
  );

  wpseq_hold #(.DEPTH(HOLD_MAX), .W($bits(wr_t))) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push),
    .push_d (wr_in),
    .pop    (pop),
    .clear  (clear),
    .head   (head),
    .cnt    (hcnt)
  );

  always_comb begin
    prot_n    = prot_q;
    win_n     = win_q;
    drain_n   = drain_q;
    pass_n    = pass_q;
    step_n    = step_q;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_w     = wr_in;
    push      = 1'b0;
    pop       = 1'b0;
    clear     = 1'b0;

    if (drain_q) begin
      // release held command bytes, oldest first
      out_valid = 1'b1;
      out_w     = head;
      pop       = out_ready;
      if (out_ready && hcnt == HCW'(1)) begin
        drain_n = 1'b0;
        pass_n  = 1'b1;
        step_n  = '0;
      end
    end else if (win_q || pass_q) begin
      out_valid = in_valid;
      in_ready  = out_ready;
      if (pass_q && in_valid && out_ready) pass_n = 1'b0;
    end else if (in_valid) begin
      if (hit_arm) begin
        in_ready = 1'b1;
        prot_n   = 1'b1;
        win_n    = 1'b1;
        step_n   = '0;
        clear    = 1'b1;
      end else if (hit_ext) begin
        in_ready = 1'b1;
        step_n   = STW'(3);
        clear    = 1'b1;
      end else if (hit_step) begin
        in_ready = 1'b1;
        push     = !prot_q && (step_q < STW'(HOLD_MAX));
        if (step_q == STW'(SEQ_LEN - 1)) begin
          prot_n = 1'b0;
          step_n = '0;
        end else begin
          step_n = step_q + STW'(1);
        end
      end else if (prot_q) begin
        in_ready = 1'b1;
        step_n   = '0;
      end else if (hcnt != '0) begin
        drain_n = 1'b1;
      end else if (step_q != '0) begin
        step_n = '0;
        pass_n = 1'b1;
      end else begin
        out_valid = 1'b1;
        in_ready  = out_ready;
      end
    end

    if (win_q && load_done) win_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q  <= 1'b0;
      win_q   <= 1'b0;
      drain_q <= 1'b0;
      pass_q  <= 1'b0;
      step_q  <= '0;
    end else begin
      prot_q  <= prot_n;
      win_q   <= win_n;
      drain_q <= drain_n;
      pass_q  <= pass_n;
      step_q  <= step_n;
    end
  end

  assign out_addr  = out_w.addr;
  assign out_data  = out_w.data;
  assign prot_on   = prot_q;
  assign wr_permit = !prot_q || win_q;
endmodule

// File: rtl/wpseq_chk.sv
module wpseq_chk
  import wpseq_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [AW-1:0] in_addr,
  input logic [DW-1:0] in_data,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic [DW-1:0] out_data,
  input logic          load_done,
  input logic          prot_on,
  input logic          wr_permit,
  input logic          win,
  input logic          drain
);
  p_no_leak_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> wr_permit);

  p_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_on && !win) |-> !out_valid);

  p_hold_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !load_done) |=>
      (out_valid && $stable(out_addr) && $stable(out_data)));

  p_drain_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drain |-> !in_ready);

  p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win) |-> prot_on);

  p_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win && load_done) |=> (!win && prot_on));

  p_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> $past(in_valid && in_ready &&
                             in_addr == KEY_ADDR_HI && in_data == KEY_D_OFF));
endmodule

bind wp_cmd_seq wpseq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_addr   (in_addr),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .out_data  (out_data),
  .load_done (load_done),
  .prot_on   (prot_on),
  .wr_permit (wr_permit),
  .win       (win_q),
  .drain     (drain_q)
);

// File: tb/sim_wp_cmd_seq.sv
`timescale 1ns/1ps
module sim_wp_cmd_seq;
  localparam int HALF = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [12:0] in_addr = '0;
  logic [7:0]  in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [12:0] out_addr;
  logic [7:0]  out_data;
  logic        load_done = 1'b0;
  logic        prot_on;
  logic        wr_permit;

  int total = 0;
  int bad   = 0;
  logic [20:0] got[$];
  logic [20:0] exp_q[$];
  bit sending = 0;

  always #HALF clk = ~clk;

  wp_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_data(out_data),
    .load_done(load_done), .prot_on(prot_on), .wr_permit(wr_permit)
  );

  // monitor: sample 1 ns before the active edge
  initial forever begin
    @(negedge clk);
    #(HALF - 1);
    if (rst_n && out_valid && out_ready) got.push_back({out_addr, out_data});
  end

  function automatic logic [20:0] seq_at(int k);
    case (k)
      0: return {13'h1555, 8'hAA};
      1: return {13'h0AAA, 8'h55};
      2: return {13'h1555, 8'h80};
      3: return {13'h1555, 8'hAA};
      4: return {13'h0AAA, 8'h55};
      default: return {13'h1555, 8'h20};
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic send(input logic [20:0] w);
    bit done = 0;
    sending = 1;
    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = w[20:8];
    in_data  = w[7:0];
    while (!done) begin
      #(HALF - 1);
      done = in_ready;
      @(negedge clk);
    end
    in_valid = 1'b0;
    sending = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk); load_done = 1'b1;
    @(negedge clk); load_done = 1'b0;
  endtask

  task automatic check_out(input string tag);
    bit ok;
    int first_a;
    int first_e;
    idle(2);
    ok = (got.size() == exp_q.size());
    if (ok) foreach (got[i]) if (got[i] !== exp_q[i]) ok = 0;
    first_a = (got.size() > 0) ? int'(got[0]) : -1;
    first_e = (exp_q.size() > 0) ? int'(exp_q[0]) : -1;
    if (!ok) $display("FAIL %s count actual=%0d expected=%0d", tag, got.size(), exp_q.size());
    check(ok, tag, first_a, first_e);
    got.delete();
    exp_q.delete();
  endtask

  task automatic arm();
    send({13'h1555, 8'hAA});
    send({13'h0AAA, 8'h55});
    send({13'h1555, 8'hA0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    #(HALF - 1);
    // R1 reset state
    check(prot_on == 1'b0, "R1 prot_on", prot_on, 0);
    check(wr_permit == 1'b1, "R1 wr_permit", wr_permit, 1);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);

    // R2 plain write passes unchanged
    send({13'h0123, 8'h5A});
    exp_q.push_back({13'h0123, 8'h5A});
    check_out("R2 plain write");

    // R7 breaking write equal to the first command byte
    send(seq_at(0));
    send(seq_at(0));
    exp_q.push_back(seq_at(0));
    exp_q.push_back(seq_at(0));
    check_out("R7 restart byte as data");

    // R7 / R8 unprotected sweep over break position and corrupted bit
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < 21; j++) begin
        logic [20:0] badw;
        badw = seq_at(k) ^ (21'd1 << j);
        if (k == 2 && badw == {13'h1555, 8'hA0}) continue;
        for (int p = 0; p < k; p++) send(seq_at(p));
        send(badw);
        if (k == 1 || k == 2) for (int p = 0; p < k; p++) exp_q.push_back(seq_at(p));
        exp_q.push_back(badw);
        check_out((k < 3) ? "R7 unprotected break" : "R8 unprotected break");
        check(prot_on == 1'b0, "R8 prot stays off", prot_on, 0);
      end
    end

    // R9 back-pressure during drain
    out_ready = 1'b0;
    send(seq_at(0));
    fork send({13'h0200, 8'h33}); join_none
    idle(3);
    #(HALF - 1);
    check(out_valid == 1'b1 && out_addr == 13'h1555 && out_data == 8'hAA,
          "R9 held byte presented", {out_addr, out_data}, {13'h1555, 8'hAA});
    check(in_ready == 1'b0, "R9 in_ready low while draining", in_ready, 0);
    idle(2);
    #(HALF - 1);
    check(out_valid == 1'b1 && out_data == 8'hAA, "R9 output stable", out_data, 8'hAA);
    out_ready = 1'b1;
    wait (sending == 0);
    exp_q.push_back(seq_at(0));
    exp_q.push_back({13'h0200, 8'h33});
    check_out("R9 drain order after stall");

    // R3 arm from unprotected state
    arm();
    check_out("R3 arm writes swallowed");
    check(prot_on == 1'b1, "R3 prot set", prot_on, 1);
    check(wr_permit == 1'b1, "R10 permit in window", wr_permit, 1);

    // R4 window load then close
    for (int i = 0; i < 3; i++) begin
      send({13'h0040 + 13'(i), 8'(8'h10 + i)});
      exp_q.push_back({13'h0040 + 13'(i), 8'(8'h10 + i)});
    end
    check_out("R4 page load forwarded");
    pulse_done();
    #(HALF - 1);
    check(wr_permit == 1'b0, "R10 permit after close", wr_permit, 0);
    check(prot_on == 1'b1, "R4 prot kept", prot_on, 1);

    // R5 protected writes dropped
    send({13'h0040, 8'hEE});
    send({13'h1FFF, 8'h01});
    check_out("R5 protected writes dropped");

    // R8 protected sweep
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < 21; j++) begin
        logic [20:0] badw;
        badw = seq_at(k) ^ (21'd1 << j);
        if (k == 2 && badw == {13'h1555, 8'hA0}) continue;
        for (int p = 0; p < k; p++) send(seq_at(p));
        send(badw);
        send({13'h0300, 8'h77});
        check_out("R8 protected break");
        check(prot_on == 1'b1 && wr_permit == 1'b0, "R5 still locked", prot_on, 1);
      end
    end

    // R3 re-arm while already protected
    arm();
    send({13'h0500, 8'h42});
    exp_q.push_back({13'h0500, 8'h42});
    check_out("R3 rearm opens window");
    pulse_done();
    send({13'h0501, 8'h43});
    check_out("R4 one load only");

    // R6 disable
    for (int p = 0; p < 6; p++) send(seq_at(p));
    check_out("R6 disable writes swallowed");
    #1;
    check(prot_on == 1'b0, "R6 prot cleared", prot_on, 0);
    send({13'h0600, 8'h99});
    exp_q.push_back({13'h0600, 8'h99});
    check_out("R6 plain write after disable");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule